// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block is the slave side of a stereo audio serial link. It runs entirely on the externally supplied bit clock and takes its alignment from an external frame clock. Playback samples arrive serially on one input line. They are gathered into parallel left and right words, and a single-cycle strobe marks each complete stereo pair. Record samples, offered as parallel left and right words, are shifted out MSB first on a second line.

Four framings are selected by a 2-bit field: left-justified, right-justified, I2S and a pulse-framed DSP mode. The DSP mode has a late-start bit that moves the first data bit back by one bit clock. Word length is 16, 20, 24 or 32 bits. Each half-frame is a fixed number of bit clocks, set by a parameter, so the bit-clock rate must be at least twice the sample rate times the half-frame length. The configured word must fit inside its half-frame, or inside the frame for DSP mode.

Top module: `audio_serial_port`

## Requirements
- R1: `fmt_sel` encodes 00 right-justified, 01 left-justified, 10 I2S and 11 DSP. In left- and right-justified framing the frame clock is high for the left channel. In I2S it is low for the left channel. Every half-frame is HALF_BITS bit clocks long, so a frame is 2*HALF_BITS, and each level change of the frame clock realigns the bit position.
- R2: In left-justified framing, the MSB is the bit sampled on the first rising bit-clock edge that sees the new frame-clock level.
- R3: In I2S framing, the MSB is sampled one bit clock after the edge where it would sit in left-justified framing.
- R4: In right-justified framing, the LSB is sampled on the last bit clock of its half-frame, and the bits before the word are don't-care.
- R5: In DSP framing, a frame starts where the frame clock is seen high after being low. With `dsp_late`=0 the left MSB is sampled on that same edge, and with `dsp_late`=1 it is sampled one bit clock later. The right word follows the left LSB with no gap.
- R6: `wlen_sel` encodes 00=16, 01=20, 10=24 and 11=32 bits. Data is MSB first. Captured words are left-aligned in 32-bit outputs with the MSB in bit 31, and the unused low bits are 0.
- R7: `sdin` and `lrclk` are sampled on the rising edge of `bclk`. `sdout` changes only on the falling edge.
- R8: `rx_valid` is high for exactly one bit clock, right after the edge that captured the right LSB. It fires only if a left word has been captured since reset or since the previous strobe. `rx_left` and `rx_right` then hold that pair.
- R9: `tx_left` and `tx_right` are sampled on the last bit clock of a frame and are sent in the next frame. Changes at any other time do not affect the frame in progress.
- R10: Bit clocks outside the configured word do not change the captured words, and during those bit clocks `sdout` is 0.
- R11: While `rst_n` is low, `rx_left`, `rx_right`, `rx_valid` and `sdout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | External bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrclk | input | 1 | External frame clock (level or pulse, per format) |
| sdin | input | 1 | Serial playback data |
| fmt_sel | input | 2 | Framing format select |
| wlen_sel | input | 2 | Word length select |
| dsp_late | input | 1 | DSP mode: data starts one bit clock after the pulse |
| tx_left | input | WORD_W | Left record word, left-aligned |
| tx_right | input | WORD_W | Right record word, left-aligned |
| rx_left | output | WORD_W | Last captured left playback word |
| rx_right | output | WORD_W | Last captured right playback word |
| rx_valid | output | 1 | One-cycle strobe for a complete stereo pair |
| sdout | output | 1 | Serial record data |

## Verification
The last bit clock of a frame can carry two events at once. In right-justified framing and at the 32-bit word length it is the right LSB, so the right word is captured and the strobe is raised. On that same edge the next frame's record words are taken in. The bench provokes this with 20-bit and 32-bit right-justified frames and with left-justified 32-bit frames, each time changing the record inputs in the middle of the frame. It judges the result twice. In the current frame it checks `rx_right` and the position of the strobe. In the following frame it checks the serial record stream, which must carry the words present at the frame end and not the earlier ones.

// File: rtl/asp_pkg.sv
package asp_pkg;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } asp_fmt_e;

  function automatic int wlen_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 16;
      2'b01:   return 20;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/asp_framer.sv
module asp_framer
  import asp_pkg::*;
#(
  parameter int HALF_BITS = 32,
  parameter int POS_W     = 6
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             lrclk,
  input  asp_fmt_e         fmt,
  output logic [POS_W-1:0] cur_pos,
  output logic [POS_W-1:0] nxt_pos,
  output logic             frame_end
);
  localparam int              FRAME_BITS = 2 * HALF_BITS;
  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(FRAME_BITS - 1);
  localparam logic [POS_W-1:0] HALF_POS  = POS_W'(HALF_BITS);

  logic [POS_W-1:0] pos_q;
  logic             lr_q;
  logic             left_lvl;

  always_comb begin
    nxt_pos  = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    left_lvl = (fmt != FMT_I2S);
    cur_pos  = nxt_pos;
    if (fmt == FMT_DSP) begin
      if (lrclk && !lr_q) cur_pos = '0;
    end else if (lrclk != lr_q) begin
      cur_pos = (lrclk == left_lvl) ? '0 : HALF_POS;
    end
    frame_end = (cur_pos == LAST_POS);
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= LAST_POS;
      lr_q  <= 1'b0;
    end else begin
      pos_q <= cur_pos;
      lr_q  <= lrclk;
    end
  end

  // R1: a frame-clock level change lands the position on a half-frame start
  assert_edge_resync_R1: assert property (@(posedge bclk) disable iff (!rst_n)
    (fmt != FMT_DSP && lrclk != lr_q) |=> (pos_q == '0 || pos_q == HALF_POS));

  // R5: a DSP frame pulse restarts the frame
  assert_pulse_resync_R5: assert property (@(posedge bclk) disable iff (!rst_n)
    (fmt == FMT_DSP && lrclk && !lr_q) |=> (pos_q == '0));

endmodule

// File: rtl/asp_slot_map.sv
module asp_slot_map
  import asp_pkg::*;
#(
  parameter int HALF_BITS = 32,
  parameter int POS_W     = 6,
  parameter int IDX_W     = 5
) (
  input  logic [POS_W-1:0] pos,
  input  asp_fmt_e         fmt,
  input  logic [1:0]       wlen_sel,
  input  logic             dsp_late,
  output logic             active,
  output logic             right,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    int wl;
    int ip;
    int k;
    wl    = wlen_bits(wlen_sel);
    ip    = int'(pos);
    right = 1'b0;
    if (fmt == FMT_DSP) begin
      k = ip - int'(dsp_late);
      if (k >= wl) begin
        k     = k - wl;
        right = 1'b1;
      end
    end else begin
      right = (ip >= HALF_BITS);
      if (right) ip = ip - HALF_BITS;
      case (fmt)
        FMT_LJ:  k = ip;
        FMT_I2S: k = ip - 1;
        default: k = ip - (HALF_BITS - wl);
      endcase
    end
    active = (k >= 0) && (k < wl);
    idx    = active ? k[IDX_W-1:0] : '0;
  end
endmodule

// File: rtl/asp_rx.sv
module asp_rx #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              sdin,
  input  logic              act,
  input  logic              rgt,
  input  logic [IDX_W-1:0]  idx,
  input  logic [IDX_W-1:0]  wl_m1,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid
);
  logic [WORD_W-1:0] acc_q, acc_n, left_q, left_n, right_q, right_n;
  logic              got_q, got_n, valid_q, valid_n;
  logic              last;
  logic [IDX_W-1:0]  bitpos;
  logic [IDX_W:0]    keep_bits;

  assign last      = act && (idx == wl_m1);
  assign bitpos    = IDX_W'(WORD_W - 1) - idx;
  assign keep_bits = {1'b0, idx} + 1'b1;

  always_comb begin
    acc_n   = acc_q;
    left_n  = left_q;
    right_n = right_q;
    got_n   = got_q;
    valid_n = 1'b0;
    if (act) begin
      if (idx == '0) acc_n = '0;
      acc_n[bitpos] = sdin;
      if (last) begin
        if (rgt) begin
          right_n = acc_n;
          if (got_q) begin
            valid_n = 1'b1;
            got_n   = 1'b0;
          end
        end else begin
          left_n = acc_n;
          got_n  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      left_q  <= '0;
      right_q <= '0;
      got_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_n;
      if (act) acc_q <= acc_n;
      if (last) begin
        left_q  <= left_n;
        right_q <= right_n;
        got_q   <= got_n;
      end
    end
  end

  assign rx_left  = left_q;
  assign rx_right = right_q;
  assign rx_valid = valid_q;

  assert_valid_single_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_valid_source_R8: assert property (@(posedge bclk) disable iff (!rst_n)
    rx_valid |-> $past(last && rgt));

  assert_left_lowzero_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    (last && !rgt) |=> ((rx_left << $past(keep_bits)) == '0));

  assert_right_lowzero_R6: assert property (@(posedge bclk) disable iff (!rst_n)
    (last && rgt) |=> ((rx_right << $past(keep_bits)) == '0));

endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  input  logic              act,
  input  logic              rgt,
  input  logic [IDX_W-1:0]  idx,
  output logic              sdout
);
  logic [WORD_W-1:0] hold_l_q, hold_r_q;
  logic [IDX_W-1:0]  bitpos;
  logic              bit_n, sdout_q;

  assign bitpos = IDX_W'(WORD_W - 1) - idx;

  always_comb begin
    bit_n = 1'b0;
    if (act) bit_n = rgt ? hold_r_q[bitpos] : hold_l_q[bitpos];
  end

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
    end else if (load) begin
      hold_l_q <= tx_left;
      hold_r_q <= tx_right;
    end
  end

  always_ff @(negedge bclk or negedge rst_n) begin
    if (!rst_n) sdout_q <= 1'b0;
    else        sdout_q <= bit_n;
  end

  assign sdout = sdout_q;

  assert_hold_frozen_R9: assert property (@(posedge bclk) disable iff (!rst_n)
    !load |=> ($stable(hold_l_q) && $stable(hold_r_q)));

endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int HALF_BITS = 32,
  parameter int WORD_W    = 32
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              lrclk,
  input  logic              sdin,
  input  logic [1:0]        fmt_sel,
  input  logic [1:0]        wlen_sel,
  input  logic              dsp_late,
  input  logic [WORD_W-1:0] tx_left,
  input  logic [WORD_W-1:0] tx_right,
  output logic [WORD_W-1:0] rx_left,
  output logic [WORD_W-1:0] rx_right,
  output logic              rx_valid,
  output logic              sdout
);
  localparam int POS_W = $clog2(2 * HALF_BITS);
  localparam int IDX_W = $clog2(WORD_W);

  asp_fmt_e         fmt;
  logic [POS_W-1:0] cur_pos, nxt_pos;
  logic             frame_end;
  logic [IDX_W-1:0] wl_m1;
  logic [POS_W-1:0] map_pos [2];
  logic             map_act [2];
  logic             map_rgt [2];
  logic [IDX_W-1:0] map_idx [2];

  assign fmt   = asp_fmt_e'(fmt_sel);
  assign wl_m1 = IDX_W'(wlen_bits(wlen_sel) - 1);

  asp_framer #(.HALF_BITS(HALF_BITS), .POS_W(POS_W)) u_framer (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .fmt(fmt),
    .cur_pos(cur_pos), .nxt_pos(nxt_pos), .frame_end(frame_end)
  );

  // index 0 maps the bit being sampled now, index 1 the bit driven next
  assign map_pos[0] = cur_pos;
  assign map_pos[1] = nxt_pos;

  for (genvar g = 0; g < 2; g++) begin : g_map
    asp_slot_map #(.HALF_BITS(HALF_BITS), .POS_W(POS_W), .IDX_W(IDX_W)) u_map (
      .pos(map_pos[g]), .fmt(fmt), .wlen_sel(wlen_sel), .dsp_late(dsp_late),
      .active(map_act[g]), .right(map_rgt[g]), .idx(map_idx[g])
    );
  end

  asp_rx #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_rx (
    .bclk(bclk), .rst_n(rst_n), .sdin(sdin),
    .act(map_act[0]), .rgt(map_rgt[0]), .idx(map_idx[0]), .wl_m1(wl_m1),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid)
  );

  asp_tx #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_tx (
    .bclk(bclk), .rst_n(rst_n), .load(frame_end),
    .tx_left(tx_left), .tx_right(tx_right),
    .act(map_act[1]), .rgt(map_rgt[1]), .idx(map_idx[1]), .sdout(sdout)
  );

endmodule

// File: tb/tb_audio_serial_port.sv
`timescale 1ns/1ps
module tb_audio_serial_port;
  localparam int CLK_NS = 10;
  localparam int HALF   = 32;
  localparam int FRAME  = 2 * HALF;

  logic        bclk, rst_n, lrclk, sdin, dsp_late, rx_valid, sdout;
  logic [1:0]  fmt_sel, wlen_sel;
  logic [31:0] tx_left, tx_right, rx_left, rx_right;
  logic [31:0] tx_cur_l, tx_cur_r;
  int          n_run, n_fail;
  bit          done;

  audio_serial_port dut (
    .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .sdin(sdin),
    .fmt_sel(fmt_sel), .wlen_sel(wlen_sel), .dsp_late(dsp_late),
    .tx_left(tx_left), .tx_right(tx_right),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid), .sdout(sdout)
  );

  initial bclk = 1'b0;
  always #(CLK_NS / 2) bclk = ~bclk;

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic int wl_of(input logic [1:0] c);
    case (c)
      2'b00:   return 16;
      2'b01:   return 20;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] mask_of(input int wl);
    return 32'hFFFF_FFFF << (32 - wl);
  endfunction

  // expected bit placement built from R1..R5
  task automatic model(input int p, output bit act, output bit rgt, output int k);
    int wl, q;
    wl  = wl_of(wlen_sel);
    rgt = 1'b0;
    if (fmt_sel == 2'b11) begin
      k = p - (dsp_late ? 1 : 0);
      if (k >= wl) begin k = k - wl; rgt = 1'b1; end
    end else begin
      rgt = (p >= HALF);
      q   = rgt ? p - HALF : p;
      if (fmt_sel == 2'b01)      k = q;
      else if (fmt_sel == 2'b10) k = q - 1;
      else                       k = q - (HALF - wl);
    end
    act = (k >= 0) && (k < wl);
  endtask

  task automatic set_cfg(input logic [1:0] f, input logic [1:0] w, input logic late);
    fmt_sel  = f;
    wlen_sel = w;
    dsp_late = late;
  endtask

  task automatic run_frame(input int start, input logic [31:0] lw, input logic [31:0] rw,
                           input logic [31:0] ntl, input logic [31:0] ntr, input string tag);
    bit act, rgt;
    int k, wl, idle_bad, edge_bad, vcnt, vbad;
    logic [31:0] cap_l, cap_r, m;
    logic pre, lvl;
    wl = wl_of(wlen_sel);
    m  = mask_of(wl);
    lvl = (fmt_sel != 2'b10);
    cap_l = '0; cap_r = '0; idle_bad = 0; edge_bad = 0; vcnt = 0; vbad = 0;
    for (int p = start; p < FRAME; p++) begin
      @(negedge bclk);
      if (fmt_sel == 2'b11) lrclk = (p == 0);
      else                  lrclk = (p < HALF) ? lvl : !lvl;
      model(p, act, rgt, k);
      sdin = act ? (rgt ? rw[31-k] : lw[31-k]) : 1'b1;
      if (p == HALF / 2) begin tx_left = ntl; tx_right = ntr; end
      #(CLK_NS / 4);
      pre = sdout;
      @(posedge bclk);
      #(CLK_NS / 4);
      if (sdout !== pre) edge_bad++;
      if (act) begin
        if (rgt) cap_r[31-k] = sdout;
        else     cap_l[31-k] = sdout;
      end else if (sdout !== 1'b0) idle_bad++;
      if (rx_valid === 1'b1) begin
        vcnt++;
        if (!(act && rgt && k == wl - 1)) vbad++;
      end
    end
    if (start == 0)
      chk(rx_left === (lw & m), {tag, " R6 R10 left word"}, rx_left, lw & m);
    chk(rx_right === (rw & m), {tag, " R6 R10 right word"}, rx_right, rw & m);
    chk(vcnt == (start == 0 ? 1 : 0) && vbad == 0, {tag, " R8 strobe count"},
        32'(vcnt), (start == 0) ? 32'd1 : 32'd0);
    chk(cap_l === (tx_cur_l & m), {tag, " R9 record left"}, cap_l, tx_cur_l & m);
    chk(cap_r === (tx_cur_r & m), {tag, " R9 record right"}, cap_r, tx_cur_r & m);
    chk(idle_bad == 0, {tag, " R10 idle output"}, 32'(idle_bad), 32'd0);
    chk(edge_bad == 0, {tag, " R7 output edge"}, 32'(edge_bad), 32'd0);
    tx_cur_l = ntl;
    tx_cur_r = ntr;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; lrclk = 1'b0; sdin = 1'b0;
    tx_left = '0; tx_right = '0; tx_cur_l = '0; tx_cur_r = '0;
    set_cfg(2'b01, 2'b10, 1'b0);
    repeat (3) @(posedge bclk);
    #(CLK_NS / 4);
    chk(rx_left === '0, "R11 reset rx_left", rx_left, '0);
    chk(rx_right === '0, "R11 reset rx_right", rx_right, '0);
    chk(rx_valid === 1'b0, "R11 reset rx_valid", 32'(rx_valid), '0);
    chk(sdout === 1'b0, "R11 reset sdout", 32'(sdout), '0);
    rst_n = 1'b1;
  endtask

  task automatic t_lj24();
    set_cfg(2'b01, 2'b10, 1'b0);
    run_frame(0, 32'hA5C3_9E11, 32'h1234_5678, 32'hC0FF_EE00, 32'h5A5A_A5A5, "R1 R2 LJ24 f0");
    run_frame(0, 32'h8000_0100, 32'h7FFF_FE00, 32'h0F0F_0F00, 32'hF00D_BA00, "R1 R2 LJ24 f1");
  endtask

  task automatic t_i2s16();
    set_cfg(2'b10, 2'b00, 1'b0);
    run_frame(0, 32'hBEEF_0000, 32'h0001_0000, 32'h8001_0000, 32'h7FFE_0000, "R1 R3 I2S16");
  endtask

  task automatic t_rj20();
    set_cfg(2'b00, 2'b01, 1'b0);
    run_frame(0, 32'h9ABC_D000, 32'h0000_1000, 32'hFEDC_B000, 32'h1357_9000, "R1 R4 RJ20");
  endtask

  task automatic t_dsp_early();
    set_cfg(2'b11, 2'b10, 1'b0);
    run_frame(0, 32'h3C3C_3C00, 32'hC3C3_C300, 32'h2468_AC00, 32'hDB97_5300, "R1 R5 DSP24 early");
  endtask

  task automatic t_dsp_late();
    set_cfg(2'b11, 2'b00, 1'b1);
    run_frame(0, 32'hF00F_0000, 32'h0FF0_0000, 32'h1111_0000, 32'hEEEE_0000, "R1 R5 DSP16 late");
  endtask

  task automatic t_full_width();
    set_cfg(2'b01, 2'b11, 1'b0);
    run_frame(0, 32'h8765_4321, 32'hFEDC_BA99, 32'h0000_0001, 32'h8000_0000, "R2 R6 LJ32");
    set_cfg(2'b00, 2'b11, 1'b0);
    run_frame(0, 32'h0000_0003, 32'hC000_0001, 32'h1234_ABCD, 32'h5555_AAAA, "R4 R6 RJ32");
    run_frame(0, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h0, 32'h0, "R4 R9 RJ32 load");
  endtask

  task automatic t_orphan();
    #(CLK_NS / 4);
    rst_n = 1'b0;
    lrclk = 1'b0;
    set_cfg(2'b10, 2'b00, 1'b0);
    tx_left = 32'hABCD_0000; tx_right = 32'h4321_0000;
    tx_cur_l = '0; tx_cur_r = '0;
    repeat (2) @(posedge bclk);
    #(CLK_NS / 4);
    rst_n = 1'b1;
    run_frame(HALF, 32'h0, 32'h6E6E_0000, 32'hABCD_0000, 32'h4321_0000, "R8 orphan right");
    chk(rx_left === '0, "R8 orphan left untouched", rx_left, '0);
    run_frame(0, 32'h1357_0000, 32'h2468_0000, 32'h0, 32'h0, "R8 after orphan");
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    t_reset();
    t_lj24();
    t_i2s16();
    t_rj20();
    t_dsp_early();
    t_dsp_late();
    t_full_width();
    t_orphan();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule